// File: doc/BRIEF.md
# Multiplier-free four-tap FIR filter

The block filters a stream of signed samples with a short FIR response whose coefficients are fixed when the design is built. It contains no multiplier. Instead it precomputes, for every subset of the taps, the sum of their coefficients and keeps those sums in a small table. The table is addressed by one bit taken from every stored sample at the same bit weight. The block walks those bit weights one per clock, starting at the least significant one. It adds each table value into a right-shifting accumulator. For the top bit weight it subtracts the value, which accounts for the negative weight of a two's complement sign bit.

A producer presents a sample with `in_valid`. The sample is taken on any clock edge where the block is idle. The block then reports `busy` for one clock per sample bit. When the sum is complete it raises `out_valid` for a single cycle, with the exact full-precision result on `out_result`. A new sample may be offered in the same cycle that the previous result appears.

Top module: `da_fir_filter`

## Requirements
- R1: For the n-th accepted sample x(n), the result equals h0·x(n) + h1·x(n−1) + h2·x(n−2) + h3·x(n−3). Tap 0 holds the newest sample. Older taps that have not yet been filled since reset count as zero.
- R2: Samples are DW-bit two's complement numbers. The most negative code (−128 at DW=8) and the most positive code (+127) give exact results.
- R3: Table entry a holds the sum of every coefficient h_k whose bit k in a is 1. Address bit k comes from tap k, so a single unit sample followed by zeros produces h0, h1, h2, h3 on four successive results.
- R4: The result is OW = DW + CW + log2(NTAPS) bits wide and never wraps, including when every tap holds an extreme value.
- R5: A sample is accepted on a rising edge where `in_valid` is 1 and `busy` is 0. `busy` is 1 in the following cycle and stays 1 for exactly DW cycles.
- R6: `out_valid` rises DW clock edges after the accepting edge, in the same cycle that `busy` falls. It stays high for one cycle only. `out_result` keeps its value until the next sample is accepted.
- R7: `in_valid` asserted while `busy` is 1 has no effect: the stored taps do not change and the result in progress is unaltered.
- R8: A synchronous active-low reset clears every tap, `busy`, `out_valid` and `out_result` to zero, and also abandons any computation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A sample is offered on `in_sample` |
| in_sample | input | DW | Signed input sample |
| busy | output | 1 | A sum is being formed; new samples are refused |
| out_valid | output | 1 | One-cycle pulse marking a finished result |
| out_result | output | DW+CW+log2(NTAPS) | Signed full-precision filter output |

## Verification
On every cycle, the assertions check the handshake timing: `busy` follows acceptance, the per-bit counter stays within the sample width, and `out_valid` is a single pulse that closes a run. They also check that the taps hold still unless a sample is taken, and that reset returns the block to idle. Whether the arithmetic is right can only be shown by the bench's scenarios. These compare each result with a direct multiply-accumulate model and cover unit impulses, extreme codes in every tap, input offered while busy, and a reset that cuts a run short.

// File: rtl/dafir_pkg.sv
// Package: shared types for the bit-serial table-lookup FIR filter.
// Assumes nothing beyond IEEE 1800-2017 enums.
package dafir_pkg;

    // Sequencer state: waiting for a sample, or walking bit slices.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

endpackage

// File: rtl/da_tap_line.sv
// Module: da_tap_line
// Holds the NTAPS most recent samples (tap 0 newest) and a working copy of
// them. The working copy is shifted right once per bit slice, so bit 0 of
// each working register is the current slice bit of that tap.
// Assumes load and shift are never asserted together.
module da_tap_line #(
    parameter int NTAPS = 4,
    parameter int DW    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 shift,
    input  logic signed [DW-1:0] sample_in,
    output logic [NTAPS-1:0]     slice
);

    logic signed [DW-1:0] tap_q  [NTAPS];
    logic signed [DW-1:0] tap_d  [NTAPS];
    logic        [DW-1:0] work_q [NTAPS];

    for (genvar k = 0; k < NTAPS; k++) begin : g_tap
        // Next tap value on a load: newest sample enters tap 0, others age by one.
        if (k == 0) begin : g_head
            assign tap_d[k] = sample_in;
        end else begin : g_body
            assign tap_d[k] = tap_q[k-1];
        end

        // Delay line register: moves only when a sample is accepted.
        always_ff @(posedge clk) begin
            if (!rst_n)    tap_q[k] <= '0;
            else if (load) tap_q[k] <= tap_d[k];
        end

        // Working copy: reloaded on accept, shifted right on each slice.
        always_ff @(posedge clk) begin
            if (!rst_n)       work_q[k] <= '0;
            else if (load)    work_q[k] <= tap_d[k];
            else if (shift)   work_q[k] <= {1'b0, work_q[k][DW-1:1]};
        end

        assign slice[k] = work_q[k][0];

        // R7: the stored history holds still on every edge without a load.
        a_r7_tap_hold : assert property (@(posedge clk) disable iff (!rst_n)
            !load |=> $stable(tap_q[k]));
    end

endmodule

// File: rtl/da_subset_lut.sv
// Module: da_subset_lut
// Combinational table of coefficient subset sums. Entry a is the sum of
// COEF[k] for every k whose bit is set in a. Width HW must hold the sum of
// NTAPS coefficients of CW bits.
module da_subset_lut #(
    parameter int NTAPS = 4,
    parameter int CW    = 8,
    parameter int HW    = 10,
    parameter logic signed [CW-1:0] COEF [NTAPS] = '{8'sd37, -8'sd91, 8'sd127, -8'sd128}
) (
    input  logic [NTAPS-1:0]     addr,
    output logic signed [HW-1:0] value
);

    localparam int DEPTH = 1 << NTAPS;

    // Sum of the coefficients selected by the set bits of an address.
    function automatic logic signed [HW-1:0] subset_sum(input int unsigned a);
        int acc;
        acc = 0;
        for (int k = 0; k < NTAPS; k++) begin
            if (a[k]) acc += int'(COEF[k]);
        end
        return HW'(acc);
    endfunction

    logic signed [HW-1:0] table_w [DEPTH];

    for (genvar a = 0; a < DEPTH; a++) begin : g_entry
        assign table_w[a] = subset_sum(a);
    end

    assign value = table_w[addr];

endmodule

// File: rtl/da_shift_acc.sv
// Module: da_shift_acc
// Right-shifting signed accumulator. Each step adds (or, for the sign
// slice, subtracts) a partial sum into the upper part, then shifts the
// whole value right by one. The bit shifted out goes into a DW-bit low
// register, so after DW steps {hi, lo} is the exact product sum.
// Assumes clear and step are never asserted together.
module da_shift_acc #(
    parameter int DW = 8,
    parameter int HW = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     step,
    input  logic                     negate,
    input  logic signed [HW-1:0]     part,
    output logic signed [HW+DW-1:0]  total
);

    logic signed [HW-1:0] hi_q;
    logic        [DW-1:0] lo_q;
    logic signed [HW:0]   hi_ext;
    logic signed [HW:0]   part_ext;
    logic signed [HW:0]   sum;

    // One guard bit so that adding or negating a table value cannot wrap.
    always_comb begin
        hi_ext   = {hi_q[HW-1], hi_q};
        part_ext = {part[HW-1], part};
        sum      = negate ? (hi_ext - part_ext) : (hi_ext + part_ext);
    end

    // Accumulator registers: cleared on a new sample, shifted on each slice.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (step) begin
            hi_q <= sum[HW:1];
            lo_q <= {sum[0], lo_q[DW-1:1]};
        end
    end

    assign total = {hi_q, lo_q};

endmodule

// File: rtl/da_fir_filter.sv
// Module: da_fir_filter
// Top level: a multiplier-free FIR filter that uses bit-serial table lookup.
// It accepts one sample when idle, spends DW clocks on one bit slice each
// (LSB first, sign slice subtracted last), then pulses out_valid with the
// full-precision result. Coefficients are fixed by the COEF parameter.
// Assumes NTAPS is a power of two and DW >= 3.
module da_fir_filter
    import dafir_pkg::*;
#(
    parameter int NTAPS = 4,
    parameter int DW    = 8,
    parameter int CW    = 8,
    parameter logic signed [CW-1:0] COEF [NTAPS] = '{8'sd37, -8'sd91, 8'sd127, -8'sd128},
    localparam int HW   = CW + $clog2(NTAPS),
    localparam int OW   = HW + DW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_sample,
    output logic                 busy,
    output logic                 out_valid,
    output logic signed [OW-1:0] out_result
);

    localparam int CNTW = $clog2(DW + 1);
    localparam logic [CNTW-1:0] LAST_BIT = CNTW'(DW - 1);

    run_state_e           state_q;
    logic [CNTW-1:0]      bit_q;
    logic                 accept;
    logic                 last_slice;
    logic                 running;
    logic [NTAPS-1:0]     slice;
    logic signed [HW-1:0] part;

    assign running    = (state_q == ST_RUN);
    assign accept     = in_valid && !running;
    assign last_slice = running && (bit_q == LAST_BIT);
    assign busy       = running;

    // Sequencer: start on accept, count slices, finish after the sign slice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            bit_q     <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= last_slice;
            if (accept) begin
                state_q <= ST_RUN;
                bit_q   <= '0;
            end else if (last_slice) begin
                state_q <= ST_IDLE;
                bit_q   <= '0;
            end else if (running) begin
                bit_q   <= bit_q + 1'b1;
            end
        end
    end

    da_tap_line #(.NTAPS(NTAPS), .DW(DW)) u_taps (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .shift     (running),
        .sample_in (in_sample),
        .slice     (slice)
    );

    da_subset_lut #(.NTAPS(NTAPS), .CW(CW), .HW(HW), .COEF(COEF)) u_lut (
        .addr  (slice),
        .value (part)
    );

    da_shift_acc #(.DW(DW), .HW(HW)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept),
        .step   (running),
        .negate (last_slice),
        .part   (part),
        .total  (out_result)
    );

    // R5: an accepted sample makes the block busy on the next cycle.
    a_r5_busy_after_accept : assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !busy) |=> busy);

    // R5: the slice counter never runs past the sample width.
    a_r5_bit_bound : assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bit_q <= LAST_BIT));

    // R6: a finished result is flagged for exactly one cycle.
    a_r6_single_pulse : assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R6: the result flag appears exactly when a run ends.
    a_r6_valid_closes_run : assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (!busy && $past(busy)));

    // R8: reset leaves the block idle with no result flagged.
    a_r8_reset_idle : assert property (@(posedge clk)
        !rst_n |=> (!busy && !out_valid));

endmodule

// File: tb/tb_da_fir_filter.sv
// Bench for da_fir_filter: walks a table of samples, then runs directed
// cases for reset, impulses, extremes and input offered while busy.
// All expected values come from a direct multiply-accumulate model.
module tb_da_fir_filter;

    localparam int CLK_PERIOD = 10;
    localparam int NT = 4;
    localparam int W  = 8;
    localparam int CWB = 8;
    localparam int OWB = W + CWB + 2;
    localparam logic signed [CWB-1:0] TB_COEF [NT] = '{8'sd37, -8'sd91, 8'sd127, -8'sd128};
    localparam int NVEC = 14;
    localparam logic signed [W-1:0] VEC [NVEC] = '{
        8'sd5, -8'sd3, 8'sd100, -8'sd77, 8'sd0, 8'sd64, -8'sd1, 8'sd42,
        -8'sd100, 8'sd17, 8'sd126, -8'sd127, 8'sd2, -8'sd64
    };

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  in_valid = 1'b0;
    logic signed [W-1:0]   in_sample = '0;
    logic                  busy;
    logic                  out_valid;
    logic signed [OWB-1:0] out_result;

    int errors = 0;
    int checks = 0;
    int hist [NT] = '{0, 0, 0, 0};

    always #(CLK_PERIOD/2) clk = ~clk;

    da_fir_filter #(.NTAPS(NT), .DW(W), .CW(CWB), .COEF(TB_COEF)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .busy       (busy),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    // Record one check; print a FAIL line with tag, actual and expected.
    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model: push a sample and return the direct product sum.
    function automatic int model_push(input int s);
        int y;
        for (int k = NT - 1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = s;
        y = 0;
        for (int k = 0; k < NT; k++) y += int'(TB_COEF[k]) * hist[k];
        return y;
    endfunction

    // Offer one sample, optionally poke in_valid while busy, check timing and result.
    task automatic send(input int s, input bit poke, input string tag);
        int c;
        int exp_y;
        @(negedge clk);
        while (busy) @(negedge clk);
        in_valid  = 1'b1;
        in_sample = W'(s);
        @(negedge clk);
        in_valid  = 1'b0;
        exp_y = model_push(s);
        chk(busy == 1'b1, "R5 busy after accept", longint'(busy), 1);
        c = 0;
        if (poke) begin
            in_valid  = 1'b1;
            in_sample = 8'sd99;
        end
        while (!out_valid && c <= 2 * W) begin
            @(negedge clk);
            c++;
            if (c == 2) in_valid = 1'b0;
            if (!out_valid) chk(busy == 1'b1, "R5 busy held", longint'(busy), 1);
        end
        in_valid = 1'b0;
        chk(c == W, "R6 latency", c, W);
        chk(int'(out_result) == exp_y, tag, longint'(int'(out_result)), exp_y);
        @(negedge clk);
        chk(out_valid == 1'b0, "R6 single pulse", longint'(out_valid), 0);
        chk(int'(out_result) == exp_y, "R6 result held", longint'(int'(out_result)), exp_y);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R8: reset state.
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R8 busy in reset", longint'(busy), 0);
        chk(out_valid == 1'b0, "R8 valid in reset", longint'(out_valid), 0);
        chk(out_result == '0, "R8 result in reset", longint'(int'(out_result)), 0);
        rst_n = 1'b1;

        // R3: unit impulse reads out h0..h3 in tap order.
        send(1, 1'b0, "R3 impulse h0");
        send(0, 1'b0, "R3 impulse h1");
        send(0, 1'b0, "R3 impulse h2");
        send(0, 1'b0, "R3 impulse h3");

        // R1: table of mixed samples.
        for (int i = 0; i < NVEC; i++) send(int'(VEC[i]), 1'b0, "R1 vector");

        // R2 / R4: extreme codes in every tap, worst-case magnitude.
        for (int i = 0; i < NT; i++) send(-128, 1'b0, "R2 all most-negative");
        for (int i = 0; i < NT; i++) send(127, 1'b0, "R2 all most-positive");
        send(-128, 1'b0, "R4 extreme mix");
        send(127, 1'b0, "R4 extreme mix");
        send(-128, 1'b0, "R4 extreme mix");
        send(127, 1'b0, "R4 worst case");

        // R7: in_valid during busy is ignored, now and for later results.
        send(-20, 1'b1, "R7 poked run");
        send(33, 1'b0, "R7 history intact");
        send(-7, 1'b1, "R7 poked run");
        send(0, 1'b0, "R7 history intact");

        // R8: reset in mid-run abandons the run and clears taps.
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = 8'sd50;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(busy == 1'b0, "R8 busy after mid-run reset", longint'(busy), 0);
        chk(out_valid == 1'b0, "R8 valid after mid-run reset", longint'(out_valid), 0);
        chk(out_result == '0, "R8 result after mid-run reset", longint'(int'(out_result)), 0);
        rst_n = 1'b1;
        for (int k = 0; k < NT; k++) hist[k] = 0;
        send(1, 1'b0, "R8 taps cleared");
        send(0, 1'b0, "R8 taps cleared");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule